// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources into one active-high interrupt request. Each source raises its own bit in a flag register with a one-cycle set pulse. Other logic can drop a flag bit with a one-cycle clear pulse, and the CPU can drop flag bits by writing the flag register. A separate enable register selects which flags may reach the request output.

A byte-wide read/write bus exposes both registers, each at its own parameterised offset. The top bit of the flag readback is not stored. It is a live indication that at least one enabled flag is set, and it always equals the request output. The enable register uses a set/clear write: bit 7 of the written byte chooses whether the ones in the low seven bits are added to the mask or removed from it.

Bus reads have no side effects. Data bits 7 down to 0 of a register correspond to bus data bits 7 down to 0.

Top module: `irqc_top`

## Requirements
- R1: After reset, all flag bits and all enable bits are 0, `irq_o` is 0, the flag register reads 0x00 and the enable register reads 0x80.
- R2: A 1 on `src_set[i]` sets flag bit i at the next rising clock edge. The bit positions are: 6 timer 1, 5 timer 2, 4 port B line 1, 3 port B line 2, 2 shift register, 1 port A line 1, 0 port A line 2.
- R3: A bus write to the flag offset clears every flag bit i (for i from 0 to 6) where data bit i is 1. Bits where the data is 0 are unchanged, and data bit 7 has no effect.
- R4: A bus write to the enable offset with data bit 7 equal to 1 ORs data bits 6..0 into the enable mask.
- R5: A bus write to the enable offset with data bit 7 equal to 0 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R6: Reading the enable offset returns bit 7 as 1 and the stored mask in bits 6..0. The mask never stores a bit 7.
- R7: Bit 7 of the flag readback and `irq_o` are both 1 exactly when the bitwise AND of the flag and enable registers is nonzero. Bits 6..0 of the flag readback are the stored flags.
- R8: `irq_o` goes low in the same cycle that the register update leaves no enabled flag set. There is no added delay.
- R9: When a set pulse and a clear (either the `src_clr` pulse or a flag-register write bit) hit the same flag bit in the same cycle, the flag ends up set.
- R10: A 1 on `src_clr[i]` clears flag bit i at the next rising clock edge, unless R9 applies.
- R11: Reads from any offset other than the flag and enable offsets return 0x00. Writes to those offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, combinational from offset and state; 0 when not reading |
| src_set | input | 7 | Per-source one-cycle set pulses |
| src_clr | input | 7 | Per-source one-cycle clear pulses |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench targets the point where the last enabled flag goes away, whether a flag is cleared or its enable bit is removed. A design that registered the summary would hold `irq_o` high for one extra cycle. It also drives a set and a clear onto the same bit at once. A design that gave the clear priority would lose an event and report a flag of 0.

The set/clear enable write is run in both directions, and it is followed by readbacks that show bit 7 as 1 while the stored mask stays seven bits wide. An implementation that stored bit 7, or that replaced the mask instead of merging into it, shows a wrong readback. The bench also checks that writing zeros to the flag register leaves flags in place, and that the unmapped offsets neither answer reads nor accept writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Decoded kind of bus access, shared by the decoder and the read mux.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_FLAG  = 2'd1,
      ACC_MASK  = 2'd2,
      ACC_OTHER = 2'd3
   } acc_e;

   // Expand a narrow set/clear mask to a full vector (helper for the mask unit).
   function automatic logic [31:0] ones_below(input int unsigned n);
      logic [31:0] v;
      v = '0;
      for (int unsigned k = 0; k < 32; k++) begin
         if (k < n) v[k] = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
   parameter int unsigned SRC_N = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] set_i,
   input  logic [SRC_N-1:0] clr_i,
   output logic [SRC_N-1:0] flag_o
);

   if (SRC_N < 1 || SRC_N > 31) begin : g_bad_src
      $error("irqc_flag_bank: SRC_N out of range");
   end

   for (genvar i = 0; i < SRC_N; i++) begin : g_cell
      logic bit_q;

      // Set has priority over any clear source in the same cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (set_i[i])   bit_q <= 1'b1;
         else if (clr_i[i])   bit_q <= 1'b0;
      end

      assign flag_o[i] = bit_q;

      a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_o[i]);

      a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[i] && clr_i[i]) |=> flag_o[i]);

      a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flag_o[i]);

      a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> (flag_o[i] == $past(flag_o[i])));
   end

endmodule

// File: rtl/irqc_enable_mask.sv
module irqc_enable_mask #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-2:0] mask_o
);

   localparam int unsigned SRC_N = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_w
      $error("irqc_enable_mask: DATA_W must be at least 2");
   end

   logic             mode_set;
   logic [SRC_N-1:0] sel_bits;
   logic [SRC_N-1:0] mask_q;
   logic [SRC_N-1:0] mask_d;

   assign mode_set = wdata[DATA_W-1];
   assign sel_bits = wdata[SRC_N-1:0];

   always_comb begin
      mask_d = mask_q;
      if (wr_en) begin
         if (mode_set) mask_d = mask_q | sel_bits;
         else          mask_d = mask_q & ~sel_bits;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign mask_o = mask_q;

   a_r4_or_in: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_set) |=> ((mask_o & $past(sel_bits)) == $past(sel_bits)));

   a_r5_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mode_set) |=> ((mask_o & $past(sel_bits)) == '0));

   a_r5_untouched_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mode_set) |=> ((mask_o & ~$past(sel_bits)) == ($past(mask_o) & ~$past(sel_bits))));

endmodule

// File: rtl/irqc_regmux.sv
module irqc_regmux
   import irqc_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  acc_e              acc,
   input  logic [DATA_W-2:0] flag_i,
   input  logic [DATA_W-2:0] mask_i,
   output logic              summary_o,
   output logic [DATA_W-1:0] rdata_o
);

   assign summary_o = |(flag_i & mask_i);

   always_comb begin
      unique case (acc)
         ACC_FLAG: rdata_o = {summary_o, flag_i};
         ACC_MASK: rdata_o = {1'b1, mask_i};
         default:  rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned FLAG_OFS = 13,
   parameter int unsigned MASK_OFS = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-2:0] src_set,
   input  logic [DATA_W-2:0] src_clr,
   output logic              irq_o
);

   localparam int unsigned SRC_N    = DATA_W - 1;
   localparam int unsigned ADDR_LIM = 1 << ADDR_W;

   if (FLAG_OFS == MASK_OFS) begin : g_bad_ofs
      $error("irqc_top: flag and enable offsets collide");
   end
   if (FLAG_OFS >= ADDR_LIM || MASK_OFS >= ADDR_LIM) begin : g_bad_range
      $error("irqc_top: offset does not fit in ADDR_W");
   end

   acc_e             acc;
   logic             flag_wr;
   logic             mask_wr;
   logic [SRC_N-1:0] clr_all;
   logic [SRC_N-1:0] flag_q;
   logic [SRC_N-1:0] mask_q;
   logic [DATA_W-1:0] mux_data;

   always_comb begin
      if (!bus_sel)                                  acc = ACC_NONE;
      else if (bus_addr == ADDR_W'(FLAG_OFS))        acc = ACC_FLAG;
      else if (bus_addr == ADDR_W'(MASK_OFS))        acc = ACC_MASK;
      else                                           acc = ACC_OTHER;
   end

   assign flag_wr = bus_we && (acc == ACC_FLAG);
   assign mask_wr = bus_we && (acc == ACC_MASK);
   assign clr_all = src_clr | (flag_wr ? bus_wdata[SRC_N-1:0] : '0);

   irqc_flag_bank #(.SRC_N(SRC_N)) flags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set),
      .clr_i  (clr_all),
      .flag_o (flag_q)
   );

   irqc_enable_mask #(.DATA_W(DATA_W)) mask_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mask_wr),
      .wdata  (bus_wdata),
      .mask_o (mask_q)
   );

   irqc_regmux #(.DATA_W(DATA_W)) mux_i (
      .acc       (acc),
      .flag_i    (flag_q),
      .mask_i    (mask_q),
      .summary_o (irq_o),
      .rdata_o   (mux_data)
   );

   assign bus_rdata = (bus_sel && !bus_we) ? mux_data : '0;

   a_r7_readback_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && acc == ACC_FLAG) |-> (bus_rdata[DATA_W-1] == irq_o));

   a_r6_mask_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && acc == ACC_MASK) |-> bus_rdata[DATA_W-1]);

   a_r11_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && acc == ACC_OTHER) |-> (bus_rdata == '0));

   a_r11_other_write_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && acc == ACC_OTHER) |=> $stable(mask_q));

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

   localparam int unsigned FLAG_A = 13;
   localparam int unsigned MASK_A = 14;
   localparam int unsigned NVEC   = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [6:0] src_set = '0;
   logic [6:0] src_clr = '0;
   logic       irq_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   irqc_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_set(src_set), .src_clr(src_clr), .irq_o(irq_o)
   );

   // Vector fields: req, we, addr, data, set, clr, exp flag read, exp enable read, exp irq
   localparam logic [47:0] VEC [NVEC] = '{
      {4'd2,  1'b0, 4'd0,  8'h00, 7'h40, 7'h00, 8'h40, 8'h80, 1'b0}, // R2 timer 1 flag
      {4'd4,  1'b1, 4'd14, 8'hC0, 7'h00, 7'h00, 8'hC0, 8'hC0, 1'b1}, // R4 enable timer 1, R7
      {4'd2,  1'b0, 4'd0,  8'h00, 7'h01, 7'h00, 8'hC1, 8'hC0, 1'b1}, // R2 port A line 2
      {4'd5,  1'b1, 4'd14, 8'h40, 7'h00, 7'h00, 8'h41, 8'h80, 1'b0}, // R5 disable timer 1
      {4'd4,  1'b1, 4'd14, 8'h83, 7'h00, 7'h00, 8'hC1, 8'h83, 1'b1}, // R4 enable bits 1,0
      {4'd8,  1'b1, 4'd13, 8'h01, 7'h00, 7'h00, 8'h40, 8'h83, 1'b0}, // R8 last enabled flag gone
      {4'd2,  1'b0, 4'd0,  8'h00, 7'h22, 7'h00, 8'hE2, 8'h83, 1'b1}, // R2 two sources at once
      {4'd10, 1'b0, 4'd0,  8'h00, 7'h00, 7'h02, 8'h60, 8'h83, 1'b0}, // R10 external clear
      {4'd9,  1'b0, 4'd0,  8'h00, 7'h08, 7'h08, 8'h68, 8'h83, 1'b0}, // R9 set and clear pulse
      {4'd3,  1'b1, 4'd13, 8'h00, 7'h00, 7'h00, 8'h68, 8'h83, 1'b0}, // R3 zeros keep flags
      {4'd6,  1'b1, 4'd14, 8'hFF, 7'h00, 7'h00, 8'hE8, 8'hFF, 1'b1}, // R6 full mask, no bit 7 stored
      {4'd3,  1'b1, 4'd13, 8'h80, 7'h00, 7'h00, 8'hE8, 8'hFF, 1'b1}, // R3 data bit 7 ignored
      {4'd9,  1'b1, 4'd13, 8'h28, 7'h08, 7'h00, 8'hC8, 8'hFF, 1'b1}, // R9 set beats bus clear
      {4'd11, 1'b1, 4'd5,  8'hFF, 7'h00, 7'h00, 8'hC8, 8'hFF, 1'b1}, // R11 unmapped write
      {4'd5,  1'b1, 4'd14, 8'h7F, 7'h00, 7'h00, 8'h48, 8'h80, 1'b0}, // R5 clear whole mask
      {4'd3,  1'b1, 4'd13, 8'h7F, 7'h00, 7'h00, 8'h00, 8'h80, 1'b0}  // R3 clear all flags
   };

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic cycle(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic [6:0] s, input logic [6:0] c);
      @(negedge clk);
      bus_sel = we; bus_we = we; bus_addr = a; bus_wdata = d;
      src_set = s; src_clr = c;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; src_set = '0; src_clr = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #2;
      v = bus_rdata;
      bus_sel = 1'b0;
      #1;
   endtask

   logic done = 1'b0;

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      rd(4'(FLAG_A), v); check8("R1 flag after reset", v, 8'h00);
      rd(4'(MASK_A), v); check8("R1 enable after reset", v, 8'h80);
      check8("R1 irq after reset", {7'd0, irq_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk
      for (int k = 0; k < NVEC; k++) begin
         logic [47:0] e;
         string t;
         e = VEC[k];
         cycle(e[43], e[42:39], e[38:31], e[30:24], e[23:17]);
         t = $sformatf("R%0d vec %0d", e[47:44], k);
         rd(4'(FLAG_A), v); check8({t, " flag (R7)"}, v, e[16:9]);
         rd(4'(MASK_A), v); check8({t, " enable (R6)"}, v, e[8:1]);
         check8({t, " irq (R7)"}, {7'd0, irq_o}, {7'd0, e[0]});
      end

      // R2 bit order: one source at a time, then bus clear (R3)
      for (int i = 0; i < 7; i++) begin
         cycle(1'b0, 4'd0, 8'h00, 7'(1 << i), 7'h00);
         rd(4'(FLAG_A), v); check8($sformatf("R2 source bit %0d", i), v, 8'(1 << i));
         cycle(1'b1, 4'(FLAG_A), 8'h7F, 7'h00, 7'h00);
         rd(4'(FLAG_A), v); check8($sformatf("R3 clear bit %0d", i), v, 8'h00);
      end

      // R11 unmapped reads return zero even with state present
      cycle(1'b0, 4'd0, 8'h00, 7'h7F, 7'h00);
      cycle(1'b1, 4'(MASK_A), 8'hFF, 7'h00, 7'h00);
      rd(4'd0, v); check8("R11 read offset 0", v, 8'h00);
      rd(4'd15, v); check8("R11 read offset 15", v, 8'h00);

      // R8 irq drops when the enable bit, not the flag, goes away
      cycle(1'b1, 4'(MASK_A), 8'h3F, 7'h00, 7'h00);
      check8("R8 irq with bit 6 only enabled", {7'd0, irq_o}, 8'h01);
      cycle(1'b1, 4'(FLAG_A), 8'h3F, 7'h00, 7'h00);
      check8("R8 irq still up on bit 6", {7'd0, irq_o}, 8'h01);
      cycle(1'b1, 4'(MASK_A), 8'h40, 7'h00, 7'h00);
      check8("R8 irq after enable removed", {7'd0, irq_o}, 8'h00);
      rd(4'(FLAG_A), v); check8("R7 flag read summary low", v, 8'h40);

      // R1 reset in mid-run
      cycle(1'b1, 4'(MASK_A), 8'hFF, 7'h00, 7'h00);
      rst_n = 1'b0;
      #3;
      rd(4'(FLAG_A), v); check8("R1 flag after mid reset", v, 8'h00);
      rd(4'(MASK_A), v); check8("R1 enable after mid reset", v, 8'h80);
      check8("R1 irq after mid reset", {7'd0, irq_o}, 8'h00);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule